// File: doc/BRIEF.md
# Maintenance Request Bus Translator

This block sits between a packet decoder and a memory-mapped register space. It accepts one decoded maintenance request at a time: read or write, a transaction size code, a word pointer, a 21-bit configuration offset, a transaction ID and a 32-bit payload. It turns each request into a single-word master read or write on the bus.

The bus byte address is built by joining a base value, held in a programmable mapping register, with the configuration offset, the word pointer and two zero bits. Only the single 32-bit word size code is carried out on the bus. Any other size code is refused without touching the bus and is answered with an error response.

Every request gets exactly one response on a valid/ready handshake. The response carries the request's transaction ID and a kind code. A saturating counter of rejected requests is kept on a status output.

Top module: `mreq_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `m_read`, `m_write` and `rsp_valid` are 0, and `err_count` is 0.
- R2: A request with `req_size` equal to 4'b1000 and `req_is_write` = 0 raises `m_read` on the cycle after it is accepted, with `m_write` low.
- R3: For an accepted request of size 4'b1000, `m_address` equals {base, `req_offset`, `req_wdptr`, 2'b00}. Here base is the mapping register value at the time of acceptance and fills the top `ADDR_W-OFFS_W-3` bits.
- R4: A size 4'b1000 request with `req_is_write` = 1 raises `m_write`, with `m_read` low, and drives `req_wdata` on `m_writedata`.
- R5: A request whose size code is not 4'b1000 starts no bus access and yields a response of kind 2'b10 with `rsp_data` = 0.
- R6: `m_read` or `m_write` stays high, with the address unchanged, for as long as `m_waitrequest` is high, and drops on the cycle after it is sampled low.
- R7: After a read is accepted by the bus, the word on `m_readdata` in the cycle `m_readdatavalid` is high is returned in a response of kind 2'b00.
- R8: After a write is accepted by the bus (`m_waitrequest` low), a response of kind 2'b01 with `rsp_data` = 0 is produced.
- R9: `req_ready` stays low from request acceptance until the response is taken (`rsp_valid` and `rsp_ready` both high), so at most one request is in flight.
- R10: A response stays valid with stable kind, data and ID while `rsp_ready` is low, and `rsp_tid` equals the `req_tid` of its request.
- R11: Every rejected request (read or write) adds one to `err_count`, which holds at its all-ones value instead of wrapping.
- R12: A pulse on `base_we` loads `base_wdata` into the mapping register. The new value is used for requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_is_write | input | 1 | 1 = write request, 0 = read request |
| req_size | input | 4 | Transaction size code |
| req_wdptr | input | 1 | Word pointer |
| req_offset | input | OFFS_W (21) | Configuration offset |
| req_tid | input | TID_W (8) | Transaction ID |
| req_wdata | input | DATA_W (32) | Write payload |
| base_we | input | 1 | Mapping register write strobe |
| base_wdata | input | ADDR_W-OFFS_W-3 (8) | New mapping base value |
| m_address | output | ADDR_W (32) | Master byte address |
| m_read | output | 1 | Master read strobe |
| m_write | output | 1 | Master write strobe |
| m_writedata | output | DATA_W (32) | Master write data |
| m_waitrequest | input | 1 | Slave stall |
| m_readdata | input | DATA_W (32) | Read data from slave |
| m_readdatavalid | input | 1 | Read data qualifier |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_kind | output | 2 | 00 read, 01 write, 10 error |
| rsp_tid | output | TID_W (8) | ID of the answered request |
| rsp_data | output | DATA_W (32) | Read data, 0 otherwise |
| err_count | output | ERR_W (8) | Saturating rejected-request count |

## Verification
The bench builds the block with the default 32-bit address and 21-bit offset, so the base field is 8 bits wide. It uses an error counter width of 3 in place of 8, which lets a short run of rejected requests drive the counter to its all-ones value and confirm that it holds there. A slave model with a variable stall length exercises the strobe-hold behaviour. Response back-pressure shows that the response holds steady and that no second request is admitted while one is in flight.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  localparam logic [3:0] SIZE_ONE_WORD = 4'b1000;

  typedef enum logic [1:0] {
    RSP_READ  = 2'b00,
    RSP_WRITE = 2'b01,
    RSP_ERROR = 2'b10
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_RDATA,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/mreq_base_reg.sv
module mreq_base_reg #(
  parameter int BASE_W = 8,
  parameter logic [BASE_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst) base_q <= RESET_VAL;
    else if (we) base_q <= wdata;
  end
endmodule

// File: rtl/mreq_err_ctr.sv
module mreq_err_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && (cnt != MAXV)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mreq_seq.sv
module mreq_seq
  import mreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 21,
  parameter int TID_W  = 8,
  parameter int BASE_W = ADDR_W - OFFS_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [3:0]        req_size,
  input  logic              req_wdptr,
  input  logic [OFFS_W-1:0] req_offset,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BASE_W-1:0] base,
  output logic              err_inc,
  output logic [ADDR_W-1:0] m_address,
  output logic              m_read,
  output logic              m_write,
  output logic [DATA_W-1:0] m_writedata,
  input  logic              m_waitrequest,
  input  logic [DATA_W-1:0] m_readdata,
  input  logic              m_readdatavalid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [DATA_W-1:0] rsp_data
);
  seq_state_e state;
  logic       size_ok;
  logic       accept;

  assign size_ok   = (req_size == SIZE_ONE_WORD);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign err_inc   = accept && !size_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      m_address   <= '0;
      m_read      <= 1'b0;
      m_write     <= 1'b0;
      m_writedata <= '0;
      rsp_valid   <= 1'b0;
      rsp_kind    <= RSP_READ;
      rsp_tid     <= '0;
      rsp_data    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rsp_tid <= req_tid;
            if (size_ok) begin
              m_address   <= {base, req_offset, req_wdptr, 2'b00};
              m_writedata <= req_is_write ? req_wdata : '0;
              m_write     <= req_is_write;
              m_read      <= !req_is_write;
              state       <= ST_BUS;
            end else begin
              rsp_valid <= 1'b1;
              rsp_kind  <= RSP_ERROR;
              rsp_data  <= '0;
              state     <= ST_RESP;
            end
          end
        end
        ST_BUS: begin
          if (!m_waitrequest) begin
            m_read  <= 1'b0;
            m_write <= 1'b0;
            if (m_write) begin
              rsp_valid <= 1'b1;
              rsp_kind  <= RSP_WRITE;
              rsp_data  <= '0;
              state     <= ST_RESP;
            end else begin
              state <= ST_RDATA;
            end
          end
        end
        ST_RDATA: begin
          if (m_readdatavalid) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= RSP_READ;
            rsp_data  <= m_readdata;
            state     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mreq_xlate.sv
module mreq_xlate #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 21,
  parameter int TID_W  = 8,
  parameter int ERR_W  = 8,
  parameter int BASE_W = ADDR_W - OFFS_W - 3,
  parameter logic [BASE_W-1:0] BASE_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [3:0]        req_size,
  input  logic              req_wdptr,
  input  logic [OFFS_W-1:0] req_offset,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] m_address,
  output logic              m_read,
  output logic              m_write,
  output logic [DATA_W-1:0] m_writedata,
  input  logic              m_waitrequest,
  input  logic [DATA_W-1:0] m_readdata,
  input  logic              m_readdatavalid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ERR_W-1:0]  err_count
);
  logic [BASE_W-1:0] base_q;
  logic              err_inc;

  mreq_base_reg #(.BASE_W(BASE_W), .RESET_VAL(BASE_RST)) u_base (
    .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata), .base_q(base_q)
  );

  mreq_err_ctr #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .inc(err_inc), .cnt(err_count)
  );

  mreq_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W),
    .TID_W(TID_W), .BASE_W(BASE_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_write(req_is_write), .req_size(req_size),
    .req_wdptr(req_wdptr), .req_offset(req_offset),
    .req_tid(req_tid), .req_wdata(req_wdata),
    .base(base_q), .err_inc(err_inc),
    .m_address(m_address), .m_read(m_read), .m_write(m_write),
    .m_writedata(m_writedata), .m_waitrequest(m_waitrequest),
    .m_readdata(m_readdata), .m_readdatavalid(m_readdatavalid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_kind(rsp_kind), .rsp_tid(rsp_tid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/mreq_xlate_chk.sv
module mreq_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 21,
  parameter int TID_W  = 8,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_size,
  input logic [ADDR_W-1:0] m_address,
  input logic              m_read,
  input logic              m_write,
  input logic              m_waitrequest,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_kind,
  input logic [TID_W-1:0]  rsp_tid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [ERR_W-1:0]  err_count
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(m_read && m_write)); // R2

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (m_read || m_write) |-> (m_address[1:0] == 2'b00)); // R3

  AST_BAD_SIZE_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size != 4'b1000) |=> (!m_read && !m_write && rsp_valid)); // R5

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((m_read || m_write) && m_waitrequest) |=>
      ((m_read || m_write) && $stable(m_address) && $stable(m_read))); // R6

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (m_read || m_write || rsp_valid) |-> !req_ready); // R9

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_kind) && $stable(rsp_tid) && $stable(rsp_data))); // R10

  AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (err_count != '0) |=> (err_count >= $past(err_count))); // R11
endmodule

bind mreq_xlate mreq_xlate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .TID_W(TID_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .m_address(m_address), .m_read(m_read),
  .m_write(m_write), .m_waitrequest(m_waitrequest), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_tid(rsp_tid),
  .rsp_data(rsp_data), .err_count(err_count)
);

// File: tb/mreq_xlate_bench.sv
`timescale 1ns/1ps
module mreq_xlate_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFFS_W = 21;
  localparam int TID_W  = 8;
  localparam int ERR_W  = 3;
  localparam int BASE_W = ADDR_W - OFFS_W - 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_is_write = 1'b0;
  logic [3:0]        req_size = 4'b1000;
  logic              req_wdptr = 1'b0;
  logic [OFFS_W-1:0] req_offset = '0;
  logic [TID_W-1:0]  req_tid = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              base_we = 1'b0;
  logic [BASE_W-1:0] base_wdata = '0;
  logic [ADDR_W-1:0] m_address;
  logic              m_read, m_write;
  logic [DATA_W-1:0] m_writedata;
  logic              m_waitrequest = 1'b1;
  logic [DATA_W-1:0] m_readdata = '0;
  logic              m_readdatavalid = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [1:0]        rsp_kind;
  logic [TID_W-1:0]  rsp_tid;
  logic [DATA_W-1:0] rsp_data;
  logic [ERR_W-1:0]  err_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [BASE_W-1:0] cur_base = '0;
  int exp_err = 0;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  always #2 clk = ~clk;

  mreq_xlate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W),
               .TID_W(TID_W), .ERR_W(ERR_W)) u_mreq_xlate (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [3:0] sz, input logic wp,
                       input logic [OFFS_W-1:0] off, input logic [TID_W-1:0] tid,
                       input logic [DATA_W-1:0] wd);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_is_write = wr; req_size = sz;
    req_wdptr = wp; req_offset = off; req_tid = tid; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
  endtask

  task automatic serve(input int stalls, input bit wr, input logic [DATA_W-1:0] rd);
    for (int i = 0; i < stalls; i++) begin
      m_waitrequest = 1'b1;
      @(negedge clk);
      chk((wr ? m_write : m_read) == 1'b1, "R6 strobe held during stall", 0, 1);
    end
    m_waitrequest = 1'b0;
    @(negedge clk);
    m_waitrequest = 1'b1;
    chk(!m_read && !m_write, "R6 strobe dropped", {m_read, m_write}, 0);
    if (!wr) begin
      repeat (2) @(negedge clk);
      m_readdatavalid = 1'b1; m_readdata = rd;
      @(negedge clk);
      m_readdatavalid = 1'b0; m_readdata = '0;
    end
  endtask

  task automatic take_rsp(input logic [1:0] kind, input logic [TID_W-1:0] tid,
                          input logic [DATA_W-1:0] data, input int hold, input string tag);
    int n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, {tag, " response valid"}, rsp_valid, 1);
    chk(rsp_kind == kind, {tag, " response kind"}, rsp_kind, kind);
    chk(rsp_tid == tid, {tag, " R10 response tid"}, rsp_tid, tid);
    chk(rsp_data == data, {tag, " response data"}, rsp_data, data);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_kind == kind && rsp_data == data, "R10 response held", rsp_data, data);
      chk(req_ready == 1'b0, "R9 ready low while response pending", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 ready after response taken", {rsp_valid, req_ready}, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(!m_read && !m_write, "R1 strobes", {m_read, m_write}, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(err_count == '0, "R1 err_count", err_count, 0);
  endtask

  task automatic t_read(input int stalls, input logic wp, input logic [OFFS_W-1:0] off,
                        input logic [TID_W-1:0] tid, input logic [DATA_W-1:0] rd);
    logic [ADDR_W-1:0] ea;
    ea = {cur_base, off, wp, 2'b00};
    issue(1'b0, 4'b1000, wp, off, tid, 32'hFFFF_FFFF);
    chk(m_read && !m_write, "R2 read strobe", {m_read, m_write}, 2);
    chk(m_address == ea, "R3 address", m_address, ea);
    serve(stalls, 1'b0, rd);
    take_rsp(2'b00, tid, rd, 0, "R7 read");
  endtask

  task automatic t_write(input int stalls, input logic wp, input logic [OFFS_W-1:0] off,
                         input logic [TID_W-1:0] tid, input logic [DATA_W-1:0] wd, input int hold);
    logic [ADDR_W-1:0] ea;
    ea = {cur_base, off, wp, 2'b00};
    issue(1'b1, 4'b1000, wp, off, tid, wd);
    chk(m_write && !m_read, "R4 write strobe", {m_read, m_write}, 1);
    chk(m_writedata == wd, "R4 write data", m_writedata, wd);
    chk(m_address == ea, "R3 write address", m_address, ea);
    serve(stalls, 1'b1, '0);
    take_rsp(2'b01, tid, '0, hold, "R8 write");
  endtask

  task automatic t_bad(input bit wr, input logic [3:0] sz, input logic [TID_W-1:0] tid);
    issue(wr, sz, 1'b1, 21'h1, tid, 32'h1234_5678);
    chk(!m_read && !m_write, "R5 no bus access", {m_read, m_write}, 0);
    if (exp_err < ERR_MAX) exp_err++;
    chk(err_count == exp_err[ERR_W-1:0], "R11 error count", err_count, exp_err);
    take_rsp(2'b10, tid, '0, 1, "R5 error");
  endtask

  task automatic t_base(input logic [BASE_W-1:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(0, 1'b0, 21'h00_0010, 8'h11, 32'hCAFE_0001);
    t_read(3, 1'b1, 21'h1F_FFFF, 8'h22, 32'h0BAD_F00D);
    t_write(0, 1'b0, 21'h0A_5A5A, 8'h33, 32'hDEAD_BEEF, 0);
    t_write(4, 1'b1, 21'h15_0F0F, 8'h44, 32'h5555_AAAA, 3);
    t_base(8'hA5);   // R12 new base for following requests
    t_read(1, 1'b1, 21'h00_0001, 8'h55, 32'h1357_9BDF);
    t_write(2, 1'b0, 21'h10_0000, 8'h66, 32'h0000_0001, 0);
    t_bad(1'b0, 4'b0000, 8'h77);
    t_bad(1'b1, 4'b1001, 8'h78);
    t_bad(1'b0, 4'b1111, 8'h79);
    t_bad(1'b1, 4'b0100, 8'h7A);
    t_bad(1'b0, 4'b1011, 8'h7B);
    t_bad(1'b1, 4'b0111, 8'h7C);
    t_bad(1'b0, 4'b0001, 8'h7D);   // reaches all-ones
    t_bad(1'b1, 4'b1100, 8'h7E);   // R11 saturation
    t_base(8'h3C);
    t_read(0, 1'b0, 21'h0C_0C0C, 8'h80, 32'hFEED_FACE);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule